// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is the combinational datapath of a small RISC core's execute stage. In one pass it takes a register operand, a second operand and the current status flags, and returns an 8-bit result. The second operand is either a register or an immediate constant. The block also returns the updated half-carry (H), overflow (V), negative (N), zero (Z) and carry (C) flags and a per-flag write mask. Each operation writes only the flags that belong to it. Flags outside the mask pass through from the flag input unchanged, so the core can write the flag output back to its status register as a whole word.

Operations are grouped into three units. The arithmetic unit covers add, subtract, negate, increment and decrement. The logic unit covers AND, OR, XOR, complement and nibble swap. The shift unit covers logical and arithmetic shifts and rotates through carry. A decode stage in the top module picks the unit, the flag mask and the result-write enable from the opcode. Compares drive the difference onto the result port but hold the write enable low. The carry-chained subtract and compare can only keep Z at 1 or clear it, which lets multi-byte compares chain from byte to byte. Flag vectors are ordered {H,V,N,Z,C}, so bit 4 is H and bit 0 is C.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) gives a+b and ADC (op 1) gives a+b+C. Both write all five flags (mask 5'b11111). H is the carry out of bit 3, V is signed overflow, N is result bit 7, Z is result==0 and C is the carry out of bit 7.
- R2: SUB (op 2) gives a-b, SBC (op 3) gives a-b-C and NEG (op 10) gives 0x00-a. All three write all five flags. H is the borrow into bit 4, C is the borrow out of bit 7, and V is signed overflow.
- R3: CP (op 4) and CPC (op 5) set the same flags as SUB and SBC and put the difference on the result port, but hold the result write enable at 0.
- R4: For SBC (op 3) and CPC (op 5), the new Z is 1 only when the difference is zero and the incoming Z was 1.
- R5: AND (op 6), OR (op 7) and XOR (op 8) write only Z, N and V (mask 5'b01110), with V=0. H and C on the flag output equal the flag input.
- R6: COM (op 9) gives 0xFF-a and writes Z, N, V and C (mask 5'b01111), with C=1 and V=0.
- R7: INC (op 11) and DEC (op 12) write only Z, N and V. V=1 only for INC of 0x7F or DEC of 0x80. C is never changed.
- R8: LSR (13), ASR (14), ROR (15), LSL (16) and ROL (17) write Z, N, V and C (mask 5'b01111). LSR shifts a 0 into bit 7, ASR keeps bit 7, ROR shifts the old C into bit 7, LSL shifts a 0 into bit 0 and ROL shifts the old C into bit 0. The bit shifted out goes to C, V=N^C, and H is kept.
- R9: SWAP (op 18) exchanges the two nibbles, has mask 0 and leaves all flags equal to the flag input.
- R10: When imm_sel_i is 1, imm_i replaces b_i as the second operand.
- R11: Every flag bit whose mask bit is 0 equals the matching bit of flags_i.
- R12: Opcodes 19 to 31 are unused. They return a unchanged, with mask 0 and result write enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First (destination) register operand |
| b_i | input | 8 | Second register operand |
| imm_i | input | 8 | Immediate constant |
| imm_sel_i | input | 1 | 1 selects imm_i as the second operand |
| flags_i | input | 5 | Current flags {H,V,N,Z,C} |
| res_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result should be written back |
| flags_o | output | 5 | Updated flags {H,V,N,Z,C} |
| flag_we_o | output | 5 | Per-flag write mask, same order |

## Verification
The bench goes after the edges of the signed range: 0x7F+1, 0x80-1, NEG of 0x80 and NEG of 0x00. A wrong overflow term or borrow sense shows up there as a wrong V or C. It checks the nibble boundaries 0x0F+1 and 0x10-1, where a half-carry taken from the wrong bit or with the wrong polarity gives a wrong H. It runs SBC with a zero difference under both values of the incoming Z; a design that sets Z from the difference alone breaks multi-byte compare chains. It also checks that INC of 0xFF leaves C alone, that logic ops and SWAP keep H and C from the flag input, and that rotates take the old carry in. A design that rotated without carry, or set flags outside the mask, would fail those checks.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W   = 8;
    localparam int OP_W    = 5;
    localparam int FLAG_N  = 5;

    // flag vector positions {H,V,N,Z,C}
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_H = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_EOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ASR  = 5'd14,
        OP_ROR  = 5'd15,
        OP_LSL  = 5'd16,
        OP_ROL  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_SHIFT = 2'd2,
        UNIT_PASS  = 2'd3
    } alu_unit_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = ALU_W
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic              cin_i,
    input  logic              zin_i,
    output logic [WIDTH-1:0]  res_o,
    output logic [FLAG_N-1:0] flags_o
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    logic [WIDTH-1:0] x_op;
    logic [WIDTH-1:0] y_op;
    logic             carry_in;
    logic             is_sub;
    logic             z_chain;
    logic [WIDTH:0]   full_sum;
    logic [HALF:0]    low_sum;
    logic [WIDTH-1:0] y_eff;
    logic             c_eff;

    always_comb begin
        x_op     = a_i;
        y_op     = b_i;
        carry_in = 1'b0;
        is_sub   = 1'b0;
        z_chain  = 1'b0;
        unique case (op_i)
            OP_ADD:  ;
            OP_ADC:  carry_in = cin_i;
            OP_SUB,
            OP_CP:   is_sub = 1'b1;
            OP_SBC,
            OP_CPC:  begin
                is_sub   = 1'b1;
                carry_in = cin_i;
                z_chain  = 1'b1;
            end
            OP_NEG:  begin
                is_sub = 1'b1;
                x_op   = '0;
                y_op   = a_i;
            end
            OP_INC:  y_op = WIDTH'(1);
            OP_DEC:  begin
                is_sub = 1'b1;
                y_op   = WIDTH'(1);
            end
            default: ;
        endcase
    end

    // subtraction as x + ~y + ~borrow_in
    always_comb begin
        y_eff    = is_sub ? ~y_op : y_op;
        c_eff    = is_sub ? ~carry_in : carry_in;
        full_sum = {1'b0, x_op} + {1'b0, y_eff} + {{WIDTH{1'b0}}, c_eff};
        low_sum  = {1'b0, x_op[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]}
                 + {{HALF{1'b0}}, c_eff};
    end

    always_comb begin
        res_o          = full_sum[WIDTH-1:0];
        flags_o        = '0;
        flags_o[FL_C]  = is_sub ? ~full_sum[WIDTH] : full_sum[WIDTH];
        flags_o[FL_H]  = is_sub ? ~low_sum[HALF] : low_sum[HALF];
        flags_o[FL_N]  = full_sum[MSB];
        flags_o[FL_V]  = (x_op[MSB] == y_eff[MSB]) && (full_sum[MSB] != x_op[MSB]);
        flags_o[FL_Z]  = (full_sum[WIDTH-1:0] == '0) && (!z_chain || zin_i);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = ALU_W
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    output logic [WIDTH-1:0]  res_o,
    output logic [FLAG_N-1:0] flags_o
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_EOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[WIDTH-1:HALF]};
            default: res_o = a_i;
        endcase
    end

    always_comb begin
        flags_o       = '0;
        flags_o[FL_N] = res_o[MSB];
        flags_o[FL_Z] = (res_o == '0);
        flags_o[FL_C] = (op_i == OP_COM);
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = ALU_W
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic              cin_i,
    output logic [WIDTH-1:0]  res_o,
    output logic [FLAG_N-1:0] flags_o
);
    localparam int MSB = WIDTH - 1;

    logic fill_bit;
    logic out_bit;
    logic to_left;

    always_comb begin
        to_left  = 1'b0;
        fill_bit = 1'b0;
        unique case (op_i)
            OP_LSR:  fill_bit = 1'b0;
            OP_ASR:  fill_bit = a_i[MSB];
            OP_ROR:  fill_bit = cin_i;
            OP_LSL:  to_left = 1'b1;
            OP_ROL:  begin
                to_left  = 1'b1;
                fill_bit = cin_i;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (to_left) begin
            res_o   = {a_i[MSB-1:0], fill_bit};
            out_bit = a_i[MSB];
        end else begin
            res_o   = {fill_bit, a_i[MSB:1]};
            out_bit = a_i[0];
        end
    end

    always_comb begin
        flags_o       = '0;
        flags_o[FL_C] = out_bit;
        flags_o[FL_N] = res_o[MSB];
        flags_o[FL_Z] = (res_o == '0);
        flags_o[FL_V] = res_o[MSB] ^ out_bit;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = ALU_W
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic [WIDTH-1:0]  imm_i,
    input  logic              imm_sel_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic [WIDTH-1:0]  res_o,
    output logic              res_we_o,
    output logic [FLAG_N-1:0] flags_o,
    output logic [FLAG_N-1:0] flag_we_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic [FLAG_N-1:0] MASK_ALL  = 5'b11111;
    localparam logic [FLAG_N-1:0] MASK_ZNV  = 5'b01110;
    localparam logic [FLAG_N-1:0] MASK_ZNVC = 5'b01111;

    logic [WIDTH-1:0]  opnd_b;
    alu_unit_e         unit_sel;
    logic [WIDTH-1:0]  arith_res, logic_res, shift_res;
    logic [FLAG_N-1:0] arith_fl, logic_fl, shift_fl;
    logic [FLAG_N-1:0] new_fl;

    assign opnd_b = imm_sel_i ? imm_i : b_i;

    // operation decode: unit, write mask, result write
    always_comb begin
        unit_sel  = UNIT_PASS;
        flag_we_o = '0;
        res_we_o  = 1'b1;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                unit_sel  = UNIT_ARITH;
                flag_we_o = MASK_ALL;
            end
            OP_CP, OP_CPC: begin
                unit_sel  = UNIT_ARITH;
                flag_we_o = MASK_ALL;
                res_we_o  = 1'b0;
            end
            OP_INC, OP_DEC: begin
                unit_sel  = UNIT_ARITH;
                flag_we_o = MASK_ZNV;
            end
            OP_AND, OP_OR, OP_EOR: begin
                unit_sel  = UNIT_LOGIC;
                flag_we_o = MASK_ZNV;
            end
            OP_COM: begin
                unit_sel  = UNIT_LOGIC;
                flag_we_o = MASK_ZNVC;
            end
            OP_SWAP: unit_sel = UNIT_LOGIC;
            OP_LSR, OP_ASR, OP_ROR, OP_LSL, OP_ROL: begin
                unit_sel  = UNIT_SHIFT;
                flag_we_o = MASK_ZNVC;
            end
            default: res_we_o = 1'b0;
        endcase
    end

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (opnd_b),
        .cin_i   (flags_i[FL_C]),
        .zin_i   (flags_i[FL_Z]),
        .res_o   (arith_res),
        .flags_o (arith_fl)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (opnd_b),
        .res_o   (logic_res),
        .flags_o (logic_fl)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .op_i    (op_i),
        .a_i     (a_i),
        .cin_i   (flags_i[FL_C]),
        .res_o   (shift_res),
        .flags_o (shift_fl)
    );

    always_comb begin
        unique case (unit_sel)
            UNIT_ARITH: begin res_o = arith_res; new_fl = arith_fl; end
            UNIT_LOGIC: begin res_o = logic_res; new_fl = logic_fl; end
            UNIT_SHIFT: begin res_o = shift_res; new_fl = shift_fl; end
            default:    begin res_o = a_i;       new_fl = '0;       end
        endcase
    end

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_merge
        assign flags_o[gi] = flag_we_o[gi] ? new_fl[gi] : flags_i[gi];
    end

    // checks on the assembled outputs
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, imm_i, imm_sel_i, flags_i})) begin
            // R3
            cmp_no_write_chk: assert (!((op_i == OP_CP || op_i == OP_CPC) && res_we_o));
            // R9
            swap_flags_chk: assert (op_i != OP_SWAP || (flag_we_o == '0 && flags_o == flags_i));
            // R1
            n_matches_msb_chk: assert (!flag_we_o[FL_N] || flags_o[FL_N] == res_o[MSB]);
            // R4
            z_matches_res_chk: assert (!flag_we_o[FL_Z] || op_i == OP_SBC || op_i == OP_CPC
                                       || flags_o[FL_Z] == (res_o == '0));
            // R8
            shift_v_chk: assert (!(op_i >= OP_LSR && op_i <= OP_ROL)
                                 || flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C]));
            // R5
            logic_v_chk: assert (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_EOR)
                                 || !flags_o[FL_V]);
            // R6
            com_carry_chk: assert (op_i != OP_COM || flags_o[FL_C]);
            // R7
            incdec_carry_chk: assert (!(op_i == OP_INC || op_i == OP_DEC)
                                      || flags_o[FL_C] == flags_i[FL_C]);
        end
    end

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic [4:0] op_i;
    logic [7:0] a_i, b_i, imm_i;
    logic       imm_sel_i;
    logic [4:0] flags_i;
    logic [7:0] res_o;
    logic       res_we_o;
    logic [4:0] flags_o;
    logic [4:0] flag_we_o;

    int tests_run    = 0;
    int tests_failed = 0;
    bit finished     = 1'b0;

    always #4 clk = ~clk;

    alu8_core dut_i (
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .flags_i   (flags_i),
        .res_o     (res_o),
        .res_we_o  (res_we_o),
        .flags_o   (flags_o),
        .flag_we_o (flag_we_o)
    );

    task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [4:0] fl);
        @(negedge clk);
        op_i      = op;
        a_i       = a;
        b_i       = b;
        flags_i   = fl;
        imm_sel_i = 1'b0;
        imm_i     = 8'h00;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [7:0] er, input logic ewe,
                              input logic [4:0] efl, input logic [4:0] emask);
        tests_run++;
        if (res_o !== er || res_we_o !== ewe || flags_o !== efl || flag_we_o !== emask) begin
            tests_failed++;
            $display("FAIL %s: got res=%h we=%b fl=%b mask=%b, expected res=%h we=%b fl=%b mask=%b",
                     tag, res_o, res_we_o, flags_o, flag_we_o, er, ewe, efl, emask);
        end
    endtask

    task automatic t_reset_state;
        apply(5'd31, 8'h00, 8'h00, 5'b00000);
        expect_out("R12 idle", 8'h00, 1'b0, 5'b00000, 5'b00000);
    endtask

    task automatic t_add;
        apply(5'd0, 8'h0F, 8'h01, 5'b00000); expect_out("R1 add half", 8'h10, 1, 5'b10000, 5'b11111);
        apply(5'd0, 8'h7F, 8'h01, 5'b00000); expect_out("R1 add ovf", 8'h80, 1, 5'b11100, 5'b11111);
        apply(5'd0, 8'hFF, 8'h01, 5'b00000); expect_out("R1 add wrap", 8'h00, 1, 5'b10011, 5'b11111);
        apply(5'd1, 8'h10, 8'h20, 5'b00001); expect_out("R1 adc", 8'h31, 1, 5'b00000, 5'b11111);
    endtask

    task automatic t_sub;
        apply(5'd2, 8'h10, 8'h01, 5'b00000); expect_out("R2 sub half", 8'h0F, 1, 5'b10000, 5'b11111);
        apply(5'd2, 8'h00, 8'h01, 5'b00000); expect_out("R2 sub borrow", 8'hFF, 1, 5'b10101, 5'b11111);
        apply(5'd2, 8'h80, 8'h01, 5'b00000); expect_out("R2 sub ovf", 8'h7F, 1, 5'b11000, 5'b11111);
        apply(5'd10, 8'h01, 8'h00, 5'b00000); expect_out("R2 neg one", 8'hFF, 1, 5'b10101, 5'b11111);
        apply(5'd10, 8'h80, 8'h00, 5'b00000); expect_out("R2 neg min", 8'h80, 1, 5'b01101, 5'b11111);
        apply(5'd10, 8'h00, 8'h00, 5'b00001); expect_out("R2 neg zero", 8'h00, 1, 5'b00010, 5'b11111);
    endtask

    task automatic t_compare_chain;
        apply(5'd4, 8'h03, 8'h05, 5'b00000); expect_out("R3 cp", 8'hFE, 0, 5'b10101, 5'b11111);
        apply(5'd3, 8'h05, 8'h05, 5'b00000); expect_out("R4 sbc z0", 8'h00, 1, 5'b00000, 5'b11111);
        apply(5'd3, 8'h05, 8'h05, 5'b00010); expect_out("R4 sbc z1", 8'h00, 1, 5'b00010, 5'b11111);
        apply(5'd5, 8'h06, 8'h05, 5'b00011); expect_out("R4 cpc", 8'h00, 0, 5'b00010, 5'b11111);
    endtask

    task automatic t_logic;
        apply(5'd6, 8'hF0, 8'h3C, 5'b11111); expect_out("R5 and", 8'h30, 1, 5'b10001, 5'b01110);
        apply(5'd7, 8'h80, 8'h01, 5'b01000); expect_out("R5 or", 8'h81, 1, 5'b00100, 5'b01110);
        apply(5'd8, 8'hAA, 8'hAA, 5'b00000); expect_out("R5 eor", 8'h00, 1, 5'b00010, 5'b01110);
        apply(5'd9, 8'h55, 8'h00, 5'b11000); expect_out("R6 com", 8'hAA, 1, 5'b10101, 5'b01111);
    endtask

    task automatic t_incdec;
        apply(5'd11, 8'h7F, 8'h00, 5'b10001); expect_out("R7 inc ovf", 8'h80, 1, 5'b11101, 5'b01110);
        apply(5'd11, 8'hFF, 8'h00, 5'b00000); expect_out("R7 inc wrap", 8'h00, 1, 5'b00010, 5'b01110);
        apply(5'd12, 8'h80, 8'h00, 5'b00000); expect_out("R7 dec ovf", 8'h7F, 1, 5'b01000, 5'b01110);
        apply(5'd12, 8'h01, 8'h00, 5'b00001); expect_out("R7 dec zero", 8'h00, 1, 5'b00011, 5'b01110);
    endtask

    task automatic t_shift;
        apply(5'd13, 8'h81, 8'h00, 5'b10000); expect_out("R8 lsr", 8'h40, 1, 5'b11001, 5'b01111);
        apply(5'd14, 8'h81, 8'h00, 5'b00000); expect_out("R8 asr", 8'hC0, 1, 5'b00101, 5'b01111);
        apply(5'd15, 8'h01, 8'h00, 5'b00000); expect_out("R8 ror out", 8'h00, 1, 5'b01011, 5'b01111);
        apply(5'd15, 8'h00, 8'h00, 5'b00001); expect_out("R8 ror in", 8'h80, 1, 5'b01100, 5'b01111);
        apply(5'd16, 8'h40, 8'h00, 5'b00001); expect_out("R8 lsl", 8'h80, 1, 5'b01100, 5'b01111);
        apply(5'd17, 8'h80, 8'h00, 5'b00001); expect_out("R8 rol", 8'h01, 1, 5'b01001, 5'b01111);
    endtask

    task automatic t_swap_unused;
        apply(5'd18, 8'h3C, 8'h00, 5'b10101); expect_out("R9 swap", 8'hC3, 1, 5'b10101, 5'b00000);
        apply(5'd19, 8'h5A, 8'h11, 5'b01010); expect_out("R12 unused", 8'h5A, 0, 5'b01010, 5'b00000);
    endtask

    task automatic t_immediate;
        @(negedge clk);
        op_i = 5'd2; a_i = 8'h10; b_i = 8'h55; imm_i = 8'h01; imm_sel_i = 1'b1; flags_i = 5'b00000;
        @(posedge clk);
        #1;
        expect_out("R10 imm sub", 8'h0F, 1, 5'b10000, 5'b11111);
    endtask

    task automatic t_passthrough;
        // R11: unmasked H and C from the input, both polarities
        apply(5'd8, 8'h01, 8'h00, 5'b10001); expect_out("R11 keep ones", 8'h01, 1, 5'b10001, 5'b01110);
        apply(5'd8, 8'h01, 8'h00, 5'b01110); expect_out("R11 keep zeros", 8'h01, 1, 5'b00000, 5'b01110);
    endtask

    initial begin
        op_i = 5'd31; a_i = '0; b_i = '0; imm_i = '0; imm_sel_i = 1'b0; flags_i = '0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_add();
        t_sub();
        t_compare_chain();
        t_logic();
        t_incdec();
        t_shift();
        t_swap_unused();
        t_immediate();
        t_passthrough();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule